// File: doc/BRIEF.md
# MDIO Management Register Interface

This block lets a host read and write the registers of an Ethernet PHY over the two-wire management bus. It has two host registers: a 16-bit data register, and a command register that holds the PHY address, the register number, a clock-range select, a write flag and a busy flag. To write a PHY register, the host loads the data register and then writes the command register with the write flag and the busy flag set. To read a PHY register, the host writes the command register with the write flag clear and the busy flag set. It then polls the busy flag. When busy reads zero, the data register holds the value returned by the PHY.

Each command sends one clause-22 frame, MSB first. The frame is 32 preamble ones, the start pattern 01, an opcode, the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround and 16 data bits. MDC is divided from the system clock by a ratio that the clock-range field selects. While the block is idle, MDC is held low and MDIO is not driven. While a frame is in flight, host writes are discarded, so a host that gives up polling early cannot corrupt the transfer.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, both host registers read as zero, MDC is low and the MDIO output enable is low.
- R2: A write to the command register (reg_sel=1) with bit 0 set starts exactly one frame of 64 MDC periods. Bit 0 then reads as 1 until the final MDC falling edge, and reads as 0 from then on. A command write with bit 0 clear updates the stored fields and produces no MDC activity.
- R3: A write frame (command bit 1 set) is driven for all 64 bits. The bits are 32 ones, 01, opcode 01, the PHY address (command bits 15:11), the register number (command bits 10:6), turnaround 10, and then the data register contents.
- R4: A read frame (command bit 1 clear) drives 32 ones, 01, opcode 10, the PHY address and the register number. It releases MDIO from the turnaround (bit 47 of the frame, counted from 1) to the end of the frame.
- R5: During a read frame, the block samples the 16 data bits on the rising edges of MDC. When busy drops, the data register (reg_sel=0) holds the sampled value, MSB first.
- R6: The clock-range field (command bits 3:2) sets the MDC half period. The values 0, 1, 2 and 3 give 10, 16, 26 and 42 system clocks. All four keep MDC at or below 2.5 MHz from a 50 MHz clock.
- R7: While busy is set, writes to either host register are ignored. The frame in flight, the stored command fields and the data register are all unchanged by them.
- R8: Between frames, MDC is low and the MDIO output enable is low.
- R9: A read of the command register returns the PHY address in bits 15:11, the register number in bits 10:6, zero in bits 5:4, the clock range in bits 3:2, the write flag in bit 1 and busy in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 1 | Register select: 0 data, 1 command |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A wrong bit pointer or a wrong shift position shows up on MDIO as a misplaced field in the captured frame. For a read, it shows up as a wrong value in the data register once busy drops. A divider that picks the wrong limit changes the time between the first two MDC rising edges, which the bench measures directly. A busy flag that is released too early or too late changes the count of MDC rising edges per frame, or causes polling to time out. A command written while busy that is not properly blocked would show up in the next frame's address fields and in the command readback.

// File: rtl/mdio_mgmt.sv
module mdio_mgmt #(
  parameter int HALF0 = 10,
  parameter int HALF1 = 16,
  parameter int HALF2 = 26,
  parameter int HALF3 = 42
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int MAXH = (HALF0 > HALF1 ? (HALF0 > HALF2 ? (HALF0 > HALF3 ? HALF0 : HALF3) : (HALF2 > HALF3 ? HALF2 : HALF3))
                                       : (HALF1 > HALF2 ? (HALF1 > HALF3 ? HALF1 : HALF3) : (HALF2 > HALF3 ? HALF2 : HALF3)));
  localparam int CW = $clog2(MAXH + 1);
  localparam int NBITS = 64;
  localparam int TA_POS = 46;
  localparam int DAT_POS = 48;

  logic          busy_q, wr_q, mdc_q;
  logic [1:0]    sel_q;
  logic [4:0]    phy_q, regn_q;
  logic [15:0]   data_q, cap_q;
  logic [NBITS-1:0] sh_q;
  logic [5:0]    idx_q;
  logic [CW-1:0] cnt_q, half_lim;
  logic          tick, frame_end, start;

  always_comb begin
    case (sel_q)
      2'd0:    half_lim = CW'(HALF0 - 1);
      2'd1:    half_lim = CW'(HALF1 - 1);
      2'd2:    half_lim = CW'(HALF2 - 1);
      default: half_lim = CW'(HALF3 - 1);
    endcase
  end

  assign tick      = busy_q && (cnt_q == half_lim);
  assign frame_end = tick && mdc_q && (idx_q == 6'(NBITS - 1));
  assign start     = reg_wr && reg_sel && !busy_q && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wr_q <= 1'b0; sel_q <= 2'd0; phy_q <= 5'd0; regn_q <= 5'd0;
      data_q <= 16'd0; cap_q <= 16'd0; sh_q <= '0; idx_q <= 6'd0; cnt_q <= '0; mdc_q <= 1'b0;
    end else begin
      if (reg_wr && !busy_q) begin
        if (reg_sel) begin
          phy_q  <= reg_wdata[15:11];
          regn_q <= reg_wdata[10:6];
          sel_q  <= reg_wdata[3:2];
          wr_q   <= reg_wdata[1];
          busy_q <= reg_wdata[0];
        end else begin
          data_q <= reg_wdata;
        end
      end
      if (start) begin
        sh_q  <= {32'hFFFF_FFFF, 2'b01, (reg_wdata[1] ? 2'b01 : 2'b10),
                  reg_wdata[15:11], reg_wdata[10:6], 2'b10, data_q};
        idx_q <= 6'd0;
        cnt_q <= '0;
        mdc_q <= 1'b0;
      end else if (busy_q) begin
        if (tick) begin
          cnt_q <= '0;
          if (!mdc_q) begin
            mdc_q <= 1'b1;
            if (!wr_q && idx_q >= 6'(DAT_POS)) cap_q <= {cap_q[14:0], mdio_i};
          end else begin
            mdc_q <= 1'b0;
            if (frame_end) begin
              busy_q <= 1'b0;
              if (!wr_q) data_q <= cap_q;
            end else begin
              idx_q <= idx_q + 6'd1;
              sh_q  <= {sh_q[NBITS-2:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign mdc       = mdc_q;
  assign mdio_o    = busy_q ? sh_q[NBITS-1] : 1'b1;
  assign mdio_oe   = busy_q && (wr_q || idx_q < 6'(TA_POS));
  assign reg_rdata = reg_sel ? {phy_q, regn_q, 2'b00, sel_q, wr_q, busy_q} : data_q;

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

  assert_mdc_edge_on_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && (mdc != $past(mdc))) |-> ($past(cnt_q) == $past(half_lim)));

  assert_busy_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && !frame_end) |=> ($stable(phy_q) && $stable(regn_q) && $stable(wr_q)
                                           && $stable(sel_q) && $stable(data_q)));

  assert_release_only_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mdio_oe) && busy_q) |-> !wr_q);

  assert_done_after_last_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(mdc) && $past(idx_q) == 6'(NBITS - 1)));
endmodule

// File: tb/mdio_mgmt_bench.sv
module mdio_mgmt_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0, mdio_i = 1'b1;
  logic [15:0] reg_wdata = 16'd0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, failures = 0;
  logic bitv [64];
  logic oev  [64];
  int rises = 0;
  logic [15:0] phy_val = 16'd0;
  realtime t1 = 0, t2 = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mdio_mgmt u_mdio_mgmt (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge mdc) begin
    if (rises < 64) begin
      bitv[rises] = mdio_o;
      oev[rises]  = mdio_oe;
    end
    if (rises == 0) t1 = $realtime;
    if (rises == 1) t2 = $realtime;
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises <= 63) mdio_i = phy_val[63 - rises];
    else mdio_i = 1'b1;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic sel, logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic hread(logic sel, output logic [15:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [15:0] r;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      hread(1'b1, r);
      if (!r[0]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [15:0] cmd(logic wr, logic [1:0] sel, logic [4:0] phy, logic [4:0] rg, logic busy);
    return {phy, rg, 2'b00, sel, wr, busy};
  endfunction

  task automatic check_frame(logic wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    logic [63:0] exp, got, oe_exp, oe_got;
    exp = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
    oe_exp = wr ? {64{1'b1}} : {{46{1'b1}}, 18'd0};
    for (int i = 0; i < 64; i++) begin
      got[63-i] = bitv[i];
      oe_got[63-i] = oev[i];
    end
    check("R2 rising edge count", 64'(rises), 64'd64);
    if (wr) check("R3 write frame bits", got, exp);
    else check("R4 read frame header", {got[63:18], 18'd0}, {exp[63:18], 18'd0});
    check(wr ? "R3 drive enable" : "R4 turnaround release", oe_got, oe_exp);
  endtask

  localparam logic [28:0] VEC [6] = '{
    {1'b1, 2'd0, 5'h01, 5'h00, 16'hA5C3},
    {1'b0, 2'd0, 5'h1F, 5'h1F, 16'h8001},
    {1'b1, 2'd1, 5'h10, 5'h0A, 16'hFFFF},
    {1'b0, 2'd2, 5'h05, 5'h11, 16'h0000},
    {1'b0, 2'd3, 5'h0C, 5'h03, 16'h5AA5},
    {1'b1, 2'd3, 5'h00, 5'h1E, 16'h0001}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    bit ok;
    int halves [4] = '{10, 16, 26, 42};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    hread(1'b1, r); check("R1 command reset", 64'(r), 64'd0);
    hread(1'b0, r); check("R1 data reset", 64'(r), 64'd0);
    check("R1 mdc/oe reset", {62'd0, mdc, mdio_oe}, 64'd0);

    foreach (VEC[k]) begin
      logic wr; logic [1:0] sel; logic [4:0] phy, rg; logic [15:0] d;
      {wr, sel, phy, rg, d} = VEC[k];
      rises = 0;
      phy_val = d;
      if (wr) hwrite(1'b0, d);
      else hwrite(1'b0, ~d);
      hwrite(1'b1, cmd(wr, sel, phy, rg, 1'b1));
      hread(1'b1, r); check("R2 busy set", 64'(r[0]), 64'd1);
      wait_idle(ok);
      check("R2 busy cleared", 64'(ok), 64'd1);
      check_frame(wr, phy, rg, d);
      check("R6 mdc period ns", 64'(int'(t2 - t1)), 64'(halves[sel] * 40));
      hread(1'b0, r);
      check(wr ? "R3 data register kept" : "R5 read data", 64'(r), 64'(d));
      hread(1'b1, r); check("R9 command readback", 64'(r), 64'(cmd(wr, sel, phy, rg, 1'b0)));
      repeat (30) @(negedge clk);
      check("R8 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    end

    rises = 0;
    hwrite(1'b1, cmd(1'b1, 2'd1, 5'h03, 5'h04, 1'b0));
    repeat (200) @(negedge clk);
    check("R2 no frame without busy", 64'(rises), 64'd0);
    hread(1'b1, r); check("R9 fields stored without busy", 64'(r), 64'(cmd(1'b1, 2'd1, 5'h03, 5'h04, 1'b0)));

    rises = 0;
    phy_val = 16'hBEEF;
    hwrite(1'b1, cmd(1'b0, 2'd0, 5'h05, 5'h02, 1'b1));
    repeat (200) @(negedge clk);
    hwrite(1'b1, cmd(1'b1, 2'd3, 5'h1F, 5'h1F, 1'b1));
    hwrite(1'b0, 16'h1234);
    hread(1'b1, r); check("R7 command held while busy", 64'(r), 64'(cmd(1'b0, 2'd0, 5'h05, 5'h02, 1'b1)));
    wait_idle(ok);
    check("R7 busy cleared", 64'(ok), 64'd1);
    check_frame(1'b0, 5'h05, 5'h02, 16'hBEEF);
    hread(1'b0, r); check("R7 data write ignored", 64'(r), 64'hBEEF);

    rises = 0;
    hwrite(1'b0, 16'hC0DE);
    hwrite(1'b1, cmd(1'b1, 2'd0, 5'h0A, 5'h15, 1'b1));
    repeat (100) @(negedge clk);
    hwrite(1'b0, 16'h0F0F);
    wait_idle(ok);
    check_frame(1'b1, 5'h0A, 5'h15, 16'hC0DE);
    hread(1'b0, r); check("R7 write payload kept", 64'(r), 64'hC0DE);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule